// File: doc/BRIEF.md
# Private Countdown Timer Pair with Watchdog Mode

This block gives one processor two private countdown units behind a small word-wide register bus. Unit 0 is a general interrupting timer. Unit 1 can act either as a second timer or as a watchdog. Both units decrement a 32-bit counter at a rate set by an 8-bit prescaler. Each unit can reload itself from its load value for periodic operation, or stop at zero after a single expiry. An expiry sets a sticky flag that software clears by writing 1 to it.

Once unit 1 enters watchdog mode, the mode bit cannot be cleared by an ordinary control write. An expiry in this mode raises a reset request instead of an interrupt. The interrupt-enable bit has no effect while the mode is active. To return to timer mode, software writes two fixed words, one after the other, to a write-only unlock register.

The bus uses word addresses. Bit 3 selects the unit, and bits 2:0 select the register inside that unit. Writes take effect at the clock edge. Reads are combinational from the register state.

Top module: `tw_timer_pair`

## Requirements
- R1: Word index 0 is the load register, 1 the live counter, 2 control, 3 expiry flag, 4 watchdog-expiry flag and 5 the unlock register. The unlock register and indices 6 and 7 always read 0. Exactly one register is written for each bus write.
- R2: A load write sets both the load value and the counter. On each prescaled tick a nonzero counter decrements by one. Counter reads return the live value.
- R3: With auto-reload (control bit 1) set, a tick that finds the counter at zero reloads it from the load value and counts as an expiry, so expiries occur every load+1 ticks.
- R4: With auto-reload clear, the counter stays at zero after its one expiry and no further expiry follows until the load or counter is written again.
- R5: Control bits 15:8 hold the prescaler P. While control bit 0 is set, one tick occurs every P+1 clocks. With bit 0 clear, no ticks occur.
- R6: In timer mode an expiry sets flag bit 0 at index 3, and writing 1 to that bit clears it. The unit's interrupt output is that flag ANDed with control bit 2. Unit 0 drives `timerIrq` and unit 1 drives `wdogIrq`.
- R7: In watchdog mode (control bit 3), an expiry sets bit 0 at index 4 and drives `resetReq`, and leaves the interrupt flag and output untouched whatever bit 2 holds. Writing 1 to that bit clears it.
- R8: Writing control with bit 3 equal to 0 does not take unit 1 out of watchdog mode. The other control fields are still updated.
- R9: Unit 1 leaves watchdog mode only when the unlock register receives 0x12345678 and then 0x87654321 as consecutive unlock writes. Any other unlock write in between restarts the sequence, and 0x12345678 always starts a new sequence.
- R10: After reset all registers read 0, both units are disabled and in timer mode, and all three outputs are low.
- R11: Unit 0 cannot enter watchdog mode, so its control bit 3 always reads 0.
- R12: A write to the counter register replaces the current count at once, and counting continues from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access valid |
| busWr | input | 1 | Write when high, read when low |
| busAddr | input | 4 | Word address: bit 3 selects the unit, bits 2:0 the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| timerIrq | output | 1 | Unit 0 interrupt |
| wdogIrq | output | 1 | Unit 1 interrupt (timer mode only) |
| resetReq | output | 1 | Reset request from a watchdog expiry |

## Verification
A bus write becomes visible on a read in the cycle after its clock edge, and a read returns the current state in the same cycle. A tick that expires sets its flag at that edge, so the interrupt or reset request is observed in the following cycle. The bench drives inputs on the falling edge. Its behavioural model advances on the same rising edge as the design. All outputs are compared at the next falling edge, and every read is compared against the model shortly after its address settles. Because of this, every result is checked in exactly the cycle it is due, with no slack allowed.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DATA_W      = 32;
  localparam int PRESC_W     = 8;
  localparam int NUM_UNITS   = 2;
  localparam int WORD_W      = 3;
  localparam int UNIT_SEL_W  = $clog2(NUM_UNITS);
  localparam int ADDR_W      = WORD_W + UNIT_SEL_W;
  localparam int CTRL_W      = 16;

  // control field positions
  localparam int CB_EN       = 0;
  localparam int CB_RELOAD   = 1;
  localparam int CB_IRQEN    = 2;
  localparam int CB_WDOG     = 3;
  localparam int CB_PRESC_LO = 8;

  localparam logic [DATA_W-1:0] UNLOCK_FIRST  = 32'h1234_5678;
  localparam logic [DATA_W-1:0] UNLOCK_SECOND = 32'h8765_4321;

  typedef enum logic [WORD_W-1:0] {
    REG_LOAD   = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_IRQST  = 3'd3,
    REG_RSTST  = 3'd4,
    REG_UNLOCK = 3'd5
  } regIdx_t;

  typedef enum logic {UL_IDLE, UL_HALF} unlockState_t;

  typedef struct packed {
    logic loadWr;
    logic countWr;
    logic ctrlWr;
    logic irqClrWr;
    logic rstClrWr;
    logic unlockWr;
  } unitStrobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] load;
    logic [DATA_W-1:0] count;
    logic [CTRL_W-1:0] ctrl;
    logic              irqFlag;
    logic              rstFlag;
  } unitView_t;
endpackage

// File: rtl/tw_prescale.sv
module tw_prescale #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [WIDTH-1:0] limit,
  output logic             tick
);
  logic [WIDTH-1:0] phase;

  // ">=" so a limit lowered mid-count still ticks promptly
  assign tick = run && (phase >= limit);

  always_ff @(posedge clk) begin
    if (!rstN)             phase <= '0;
    else if (!run || tick) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  p_idle_no_tick_r5: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (phase == '0));
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busSel,
  input  logic                             busWr,
  input  logic [ADDR_W-1:0]                busAddr,
  input  unitView_t   [NUM_UNITS-1:0]      views,
  output unitStrobe_t [NUM_UNITS-1:0]      strobes,
  output logic [DATA_W-1:0]                busRdata
);
  logic [WORD_W-1:0]     wordIdx;
  logic [UNIT_SEL_W-1:0] unitIdx;

  assign wordIdx = busAddr[WORD_W-1:0];
  assign unitIdx = busAddr[ADDR_W-1:WORD_W];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_dec
    logic hit;
    assign hit = busSel && busWr && (int'(unitIdx) == u);
    assign strobes[u].loadWr   = hit && (wordIdx == REG_LOAD);
    assign strobes[u].countWr  = hit && (wordIdx == REG_COUNT);
    assign strobes[u].ctrlWr   = hit && (wordIdx == REG_CTRL);
    assign strobes[u].irqClrWr = hit && (wordIdx == REG_IRQST);
    assign strobes[u].rstClrWr = hit && (wordIdx == REG_RSTST);
    assign strobes[u].unlockWr = hit && (wordIdx == REG_UNLOCK);
  end

  always_comb begin
    unitView_t v;
    v = views[unitIdx];
    case (wordIdx)
      REG_LOAD:  busRdata = v.load;
      REG_COUNT: busRdata = v.count;
      REG_CTRL:  busRdata = {{(DATA_W-CTRL_W){1'b0}}, v.ctrl};
      REG_IRQST: busRdata = {{(DATA_W-1){1'b0}}, v.irqFlag};
      REG_RSTST: busRdata = {{(DATA_W-1){1'b0}}, v.rstFlag};
      default:   busRdata = '0;
    endcase
  end

  p_single_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  p_read_no_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || !busWr) |-> (strobes == '0));
endmodule

// File: rtl/tw_unit.sv
module tw_unit
  import tw_pkg::*;
#(
  parameter bit WDOG_CAPABLE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  unitStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  output unitView_t         view,
  output logic              irqOut,
  output logic              rstOut
);
  logic               enable, autoReload, irqEnable, wdMode;
  logic [PRESC_W-1:0] presc;
  logic [DATA_W-1:0]  loadVal, count;
  logic               armed, irqFlag, rstFlag, tick, fire, countZero;

  tw_prescale #(.WIDTH(PRESC_W)) u_presc (
    .clk   (clk),
    .rstN  (rstN),
    .run   (enable),
    .limit (presc),
    .tick  (tick)
  );

  assign countZero = (count == '0);
  assign fire      = tick && countZero && armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable     <= 1'b0;
      autoReload <= 1'b0;
      irqEnable  <= 1'b0;
      presc      <= '0;
    end else if (strobe.ctrlWr) begin
      enable     <= wdata[CB_EN];
      autoReload <= wdata[CB_RELOAD];
      irqEnable  <= wdata[CB_IRQEN];
      presc      <= wdata[CB_PRESC_LO +: PRESC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              loadVal <= '0;
    else if (strobe.loadWr) loadVal <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      armed <= 1'b0;
    end else if (strobe.loadWr || strobe.countWr) begin
      count <= wdata;
      armed <= 1'b1;
    end else if (tick) begin
      if (!countZero)                count <= count - 1'b1;
      else if (fire && autoReload)   count <= loadVal;
      if (fire && !autoReload)       armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                irqFlag <= 1'b0;
    else if (fire && !wdMode)                 irqFlag <= 1'b1;
    else if (strobe.irqClrWr && wdata[0])     irqFlag <= 1'b0;
  end

  if (WDOG_CAPABLE) begin : g_wdog
    unlockState_t ulState;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wdMode  <= 1'b0;
        ulState <= UL_IDLE;
      end else begin
        if (strobe.ctrlWr && wdata[CB_WDOG]) wdMode <= 1'b1;
        if (strobe.unlockWr) begin
          if (wdata == UNLOCK_FIRST) begin
            ulState <= UL_HALF;
          end else if (ulState == UL_HALF && wdata == UNLOCK_SECOND) begin
            ulState <= UL_IDLE;
            wdMode  <= 1'b0;
          end else begin
            ulState <= UL_IDLE;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)                            rstFlag <= 1'b0;
      else if (fire && wdMode)              rstFlag <= 1'b1;
      else if (strobe.rstClrWr && wdata[0]) rstFlag <= 1'b0;
    end

    p_wd_exit_unlock_r9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(wdMode) |-> $past(strobe.unlockWr));
    p_wd_expiry_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
      (fire && wdMode) |=> rstOut);
  end else begin : g_plain
    logic unusedStrobes;
    assign wdMode        = 1'b0;
    assign rstFlag       = 1'b0;
    assign unusedStrobes = strobe.rstClrWr ^ strobe.unlockWr;
  end

  assign irqOut = irqFlag && irqEnable && !wdMode;
  assign rstOut = rstFlag;

  assign view.load    = loadVal;
  assign view.count   = count;
  assign view.ctrl    = {presc, 4'b0000, wdMode, irqEnable, autoReload, enable};
  assign view.irqFlag = irqFlag;
  assign view.rstFlag = rstFlag;

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !countZero && !strobe.loadWr && !strobe.countWr)
      |=> (count == $past(count) - 1'b1));
  p_oneshot_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && countZero && !armed && !strobe.loadWr && !strobe.countWr)
      |=> (count == '0));
  p_tick_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tick && presc != '0 && !strobe.ctrlWr) |=> !tick);
  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !strobe.irqClrWr) |=> irqFlag);
  p_no_irq_in_wd_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> !$past(wdMode));
endmodule

// File: rtl/tw_timer_pair.sv
module tw_timer_pair
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [3:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              timerIrq,
  output logic              wdogIrq,
  output logic              resetReq
);
  unitStrobe_t [NUM_UNITS-1:0] strobes;
  unitView_t   [NUM_UNITS-1:0] views;
  logic        [NUM_UNITS-1:0] irqVec;
  logic        [NUM_UNITS-1:0] rstVec;

  tw_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .views    (views),
    .strobes  (strobes),
    .busRdata (busRdata)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    tw_unit #(.WDOG_CAPABLE(u == NUM_UNITS - 1)) u_unit (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobes[u]),
      .wdata  (busWdata),
      .view   (views[u]),
      .irqOut (irqVec[u]),
      .rstOut (rstVec[u])
    );
  end

  assign timerIrq = irqVec[0];
  assign wdogIrq  = irqVec[NUM_UNITS-1];
  assign resetReq = |rstVec;

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |=> (!timerIrq && !wdogIrq && !resetReq));
endmodule

// File: tb/tw_timer_pair_tb.sv
module tw_timer_pair_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        timerIrq, wdogIrq, resetReq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  localparam logic [31:0] K1 = 32'h1234_5678;
  localparam logic [31:0] K2 = 32'h8765_4321;

  always #5 clk = ~clk;

  tw_timer_pair u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .timerIrq(timerIrq),
    .wdogIrq(wdogIrq), .resetReq(resetReq)
  );

  // behavioural reference model
  logic [31:0] mLoad [2];
  logic [31:0] mCnt [2];
  int          mPc [2];
  int          mPresc [2];
  bit mEn [2], mAr [2], mIe [2], mWd [2], mArmed [2], mIsr [2], mWrs [2];
  bit mUl;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < 2; u++) begin
        mLoad[u] = 0; mCnt[u] = 0; mPc[u] = 0; mPresc[u] = 0;
        mEn[u] = 0; mAr[u] = 0; mIe[u] = 0; mWd[u] = 0;
        mArmed[u] = 0; mIsr[u] = 0; mWrs[u] = 0;
      end
      mUl = 0;
    end else begin
      for (int u = 0; u < 2; u++) begin
        bit wrHere, tk, fr;
        int idx;
        wrHere = busSel && busWr && (int'(busAddr[3]) == u);
        idx = int'(busAddr[2:0]);
        tk = mEn[u] && (mPc[u] >= mPresc[u]);
        fr = tk && (mCnt[u] == 0) && mArmed[u];
        if (!mEn[u] || tk) mPc[u] = 0; else mPc[u] = mPc[u] + 1;
        if (wrHere && (idx == 0 || idx == 1)) begin
          mCnt[u] = busWdata; mArmed[u] = 1;
          if (idx == 0) mLoad[u] = busWdata;
        end else if (tk) begin
          if (mCnt[u] != 0) mCnt[u] = mCnt[u] - 1;
          else if (fr && mAr[u]) mCnt[u] = mLoad[u];
          if (fr && !mAr[u]) mArmed[u] = 0;
        end
        if (fr && !mWd[u]) mIsr[u] = 1;
        else if (wrHere && idx == 3 && busWdata[0]) mIsr[u] = 0;
        if (fr && mWd[u]) mWrs[u] = 1;
        else if (wrHere && idx == 4 && busWdata[0]) mWrs[u] = 0;
        if (wrHere && idx == 2) begin
          mEn[u] = busWdata[0]; mAr[u] = busWdata[1]; mIe[u] = busWdata[2];
          mPresc[u] = int'(busWdata[15:8]);
          if (u == 1 && busWdata[3]) mWd[u] = 1;
        end
        if (u == 1 && wrHere && idx == 5) begin
          if (busWdata == K1) mUl = 1;
          else if (mUl && busWdata == K2) begin mUl = 0; mWd[1] = 0; end
          else mUl = 0;
        end
      end
    end
  end

  function automatic logic [31:0] mRead(logic [3:0] a);
    int u;
    u = int'(a[3]);
    case (a[2:0])
      3'd0: return mLoad[u];
      3'd1: return mCnt[u];
      3'd2: return {16'b0, 8'(mPresc[u]), 4'b0, mWd[u], mIe[u], mAr[u], mEn[u]};
      3'd3: return {31'b0, mIsr[u]};
      3'd4: return {31'b0, mWrs[u]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // per-cycle output comparison (R6, R7)
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R6", "timerIrq", {31'b0, timerIrq}, {31'b0, mIsr[0] && mIe[0]});
      check("R6", "wdogIrq", {31'b0, wdogIrq}, {31'b0, mIsr[1] && mIe[1] && !mWd[1]});
      check("R7", "resetReq", {31'b0, resetReq}, {31'b0, mWrs[1]});
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0;
  endtask

  task automatic rd(logic [3:0] a, string tag);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    check(tag, "read", busRdata, mRead(a));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1_500_000;
    miscompares++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1;
    // R10: reset state
    for (int a = 0; a < 16; a++) rd(4'(a), "R10");
    check("R10", "outputs", {29'b0, timerIrq, wdogIrq, resetReq}, 32'h0);

    // R2, R3: periodic count on unit 0
    wr(4'h0, 32'd5);
    rd(4'h1, "R2");
    wr(4'h2, 32'h7);
    for (int i = 0; i < 20; i++) rd(4'h1, "R3");
    rd(4'h3, "R6");
    wr(4'h3, 32'h1);   // R6 clear
    rd(4'h3, "R6");
    wr(4'h3, 32'h0);   // R6 writing 0 leaves flag
    rd(4'h3, "R6");

    // R5: prescaler 3
    wr(4'h0, 32'd2);
    wr(4'h2, 32'h0307);
    for (int i = 0; i < 40; i++) rd(4'h1, "R5");
    wr(4'h2, 32'h0306);  // disabled, no ticks
    for (int i = 0; i < 6; i++) rd(4'h1, "R5");

    // R4: one-shot
    wr(4'h3, 32'h1);
    wr(4'h0, 32'd3);
    wr(4'h2, 32'h0005);
    for (int i = 0; i < 20; i++) rd(4'h1, "R4");
    rd(4'h3, "R4");
    wr(4'h3, 32'h1);
    idle(10);
    rd(4'h3, "R4");

    // R12: counter overwrite
    wr(4'h1, 32'd9);
    rd(4'h1, "R12");
    for (int i = 0; i < 12; i++) rd(4'h1, "R12");

    // R11: unit 0 refuses watchdog mode
    wr(4'h2, 32'h000F);
    rd(4'h2, "R11");
    idle(8);
    wr(4'h2, 32'h0);

    // unit 1 as a plain timer (R6)
    wr(4'h8, 32'd4);
    wr(4'hA, 32'h7);
    idle(12);
    rd(4'hB, "R6");
    wr(4'hB, 32'h1);
    wr(4'hA, 32'h0);
    rd(4'hB, "R6");

    // R7: watchdog mode, interrupt enable ignored
    wr(4'h8, 32'd3);
    wr(4'hA, 32'h000F);
    rd(4'hA, "R7");
    idle(12);
    rd(4'hC, "R7");
    rd(4'hB, "R7");
    wr(4'hA, 32'h000A);  // stop counting, bit 3 still set
    wr(4'hC, 32'h1);
    rd(4'hC, "R7");

    // R8: clearing bit 3 by control write has no effect
    wr(4'hA, 32'h0006);
    rd(4'hA, "R8");

    // R9: broken sequences keep watchdog mode
    wr(4'hD, K1); wr(4'hD, 32'h5); wr(4'hD, K2);
    rd(4'hA, "R9");
    wr(4'hD, K2);
    rd(4'hA, "R9");
    rd(4'hD, "R1");
    rd(4'hE, "R1");
    rd(4'h7, "R1");
    // restart via repeated first word, then complete
    wr(4'hD, K1); wr(4'hD, K1); wr(4'hD, K2);
    rd(4'hA, "R9");
    wr(4'hA, 32'h0);
    rd(4'hA, "R9");

    // back in timer mode: expiry interrupts again (R6)
    wr(4'h8, 32'd1);
    wr(4'hA, 32'h0005);
    idle(6);
    rd(4'hB, "R6");
    rd(4'hC, "R7");
    idle(2);
    finishRun();
  end
endmodule